// File: doc/BRIEF.md
# Gated Serial Bitstream Receiver

This block takes a compressed audio bitstream delivered one bit at a time on a data line, timed by a bit clock that the source owns. A per-bit qualifier input says which bits are real. The bit clock, data and qualifier are brought into the system clock domain, and each usable bit is taken on the bit-clock edge chosen by a configuration input. Eight such bits form a byte, most significant bit first. The byte then goes into an internal byte FIFO, which the downstream decoder drains through a show-ahead read port.

Flow control back to the source comes from a data-request output, driven by a two-state machine that watches the FIFO fill level. In `REQ_OPEN` the source may send. The transition `fill_hits_high` moves the machine to `REQ_HOLD` when the fill reaches the FIFO depth minus four bytes. In `REQ_HOLD` the source must pause. The transition `fill_below_low` returns the machine to `REQ_OPEN` once the fill drops below half the depth. A second configuration input inverts the request polarity. The system clock must run at least four times faster than the bit clock.

Top module: `bitstream_rx`

## Requirements
- R1: Bits are assembled most significant bit first: the first qualified bit after reset, or after a completed byte, becomes bit 7 of the byte.
- R2: With `cfg_fall_edge` = 0 the data line is sampled at the rising bit-clock edge. With `cfg_fall_edge` = 1 it is sampled at the falling edge.
- R3: A bit whose `bit_gate` is low when its sampling edge arrives is ignored and does not advance byte assembly.
- R4: A byte enters the FIFO only after eight qualified bits. With seven qualified bits received, `rd_valid` stays 0.
- R5: Bytes leave the FIFO in arrival order. `rd_valid` is 1 exactly while the FIFO holds data, `rd_data` shows the oldest byte, and a cycle with `rd_en` high removes that byte.
- R6: In default polarity (`cfg_req_inv` = 0), `data_req` is 1 while the state is `REQ_OPEN`. It drops to 0 once the FIFO holds DEPTH-4 bytes (12 at default size). At 11 bytes it is still 1.
- R7: After `data_req` has dropped, it stays inactive while the fill is at least DEPTH/2 (8). It becomes active again once the fill falls to 7 or fewer.
- R8: With `cfg_req_inv` = 1, `data_req` is the complement of the default-polarity value: 0 while the source may send and 1 while it must stop.
- R9: Reset empties the FIFO, returns the machine to `REQ_OPEN` and discards any partially assembled byte.
- R10: A byte completed while the FIFO already holds DEPTH bytes is dropped, and the FIFO contents stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Bit clock from the source |
| ser_dat | input | 1 | Serial data, MSB first |
| bit_gate | input | 1 | Bit qualifier; low means the bit is ignored |
| cfg_fall_edge | input | 1 | 0: sample on rising edge, 1: sample on falling edge |
| cfg_req_inv | input | 1 | 1 inverts the polarity of `data_req` |
| rd_en | input | 1 | Pop the oldest byte |
| rd_data | output | 8 | Oldest byte in the FIFO |
| rd_valid | output | 1 | FIFO not empty |
| data_req | output | 1 | Flow-control request to the source |

## Verification
A wrong bit count or shift direction shows up at `rd_data` when the affected byte reaches the head of the FIFO. That is about four system cycles after its eighth sampling edge. Sampling on the wrong edge is made visible by changing the data line between the two edges: every bit then arrives complemented. A fill-threshold or state error shows on `data_req` within two cycles of the push or pop that crosses 12, or that drops below 8. Overflow errors appear as lost or changed bytes when a full FIFO is drained.

// File: rtl/bitstream_rx_pkg.sv
package bitstream_rx_pkg;
    typedef enum logic {
        REQ_OPEN = 1'b0,
        REQ_HOLD = 1'b1
    } req_state_t;
endpackage

// File: rtl/rx_edge_sync.sv
module rx_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_dat,
    input  logic bit_gate,
    input  logic cfg_fall_edge,
    output logic bit_stb,
    output logic bit_val
);
    logic [1:0] clk_sy, dat_sy, gate_sy;
    logic       clk_last;
    logic       rise_ev, fall_ev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_sy   <= '0;
            dat_sy   <= '0;
            gate_sy  <= '0;
            clk_last <= 1'b0;
        end else begin
            clk_sy   <= {clk_sy[0], ser_clk};
            dat_sy   <= {dat_sy[0], ser_dat};
            gate_sy  <= {gate_sy[0], bit_gate};
            clk_last <= clk_sy[1];
        end
    end

    assign rise_ev = clk_sy[1] & ~clk_last;
    assign fall_ev = ~clk_sy[1] & clk_last;
    assign bit_stb = (cfg_fall_edge ? fall_ev : rise_ev) & gate_sy[1];
    assign bit_val = dat_sy[1];
endmodule

// File: rtl/rx_byte_packer.sv
module rx_byte_packer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    output logic              byte_push,
    output logic [BYTE_W-1:0] byte_data
);
    localparam int CW = $clog2(BYTE_W);

    logic [BYTE_W-2:0] shreg;
    logic [CW-1:0]     bit_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bit_cnt   <= '0;
            byte_push <= 1'b0;
            byte_data <= '0;
        end else begin
            byte_push <= 1'b0;
            if (bit_stb) begin
                if (bit_cnt == CW'(BYTE_W - 1)) begin
                    byte_data <= {shreg, bit_val};
                    byte_push <= 1'b1;
                    bit_cnt   <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
                shreg <= {shreg[BYTE_W-3:0], bit_val};
            end
        end
    end

    AST_PUSH_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        byte_push |-> $past(bit_stb)); // R4
endmodule

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo #(
    parameter int AW     = 4,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              pop,
    output logic [BYTE_W-1:0] head,
    output logic              not_empty,
    output logic [AW:0]       fill
);
    localparam int DEPTH = 1 << AW;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic              do_push, do_pop;

    assign do_push = push && (fill != (AW+1)'(DEPTH));
    assign do_pop  = pop && (fill != '0);

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            fill <= fill + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    assign head      = mem[rptr];
    assign not_empty = (fill != '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= (AW+1)'(DEPTH)); // R10
    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && fill != '0) |=> fill == (AW+1)'($past(fill) - 1'b1)); // R5
endmodule

// File: rtl/rx_req_fsm.sv
module rx_req_fsm
    import bitstream_rx_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [AW:0] fill,
    input  logic        cfg_req_inv,
    output logic        data_req
);
    localparam int DEPTH = 1 << AW;
    localparam int HIGH  = DEPTH - 4;
    localparam int LOW   = DEPTH / 2;

    req_state_t state, state_nx;
    logic       fill_hits_high, fill_below_low;

    assign fill_hits_high = fill >= (AW+1)'(HIGH);
    assign fill_below_low = fill <  (AW+1)'(LOW);

    always_comb begin
        state_nx = state;
        unique case (state)
            REQ_OPEN: if (fill_hits_high) state_nx = REQ_HOLD;
            REQ_HOLD: if (fill_below_low) state_nx = REQ_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= REQ_OPEN;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            REQ_OPEN: data_req = ~cfg_req_inv;
            REQ_HOLD: data_req = cfg_req_inv;
        endcase
    end

    AST_HOLD_AT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        fill_hits_high |=> state == REQ_HOLD); // R6
    AST_HYSTERESIS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == REQ_HOLD && !fill_below_low) |=> state == REQ_HOLD); // R7
endmodule

// File: rtl/bitstream_rx.sv
module bitstream_rx #(
    parameter int FIFO_AW = 4,
    parameter int BYTE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              bit_gate,
    input  logic              cfg_fall_edge,
    input  logic              cfg_req_inv,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              data_req
);
    logic              bit_stb, bit_val;
    logic              byte_push;
    logic [BYTE_W-1:0] byte_data;
    logic [FIFO_AW:0]  fill;

    rx_edge_sync u_sync (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .bit_gate(bit_gate), .cfg_fall_edge(cfg_fall_edge),
        .bit_stb(bit_stb), .bit_val(bit_val)
    );

    rx_byte_packer #(.BYTE_W(BYTE_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
        .byte_push(byte_push), .byte_data(byte_data)
    );

    rx_byte_fifo #(.AW(FIFO_AW), .BYTE_W(BYTE_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(byte_push), .push_data(byte_data),
        .pop(rd_en), .head(rd_data), .not_empty(rd_valid), .fill(fill)
    );

    rx_req_fsm #(.AW(FIFO_AW)) u_req (
        .clk(clk), .rst_n(rst_n), .fill(fill), .cfg_req_inv(cfg_req_inv),
        .data_req(data_req)
    );

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(fill) == '0); // R9
endmodule

// File: tb/bitstream_rx_test.sv
module bitstream_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0, ser_dat = 1'b0, bit_gate = 1'b0;
    logic       cfg_fall_edge = 1'b0, cfg_req_inv = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid, data_req;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    logic [7:0] model[$];

    always #10 clk = ~clk;

    bitstream_rx uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .bit_gate(bit_gate), .cfg_fall_edge(cfg_fall_edge),
        .cfg_req_inv(cfg_req_inv), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .data_req(data_req)
    );

    // {fall_edge, junk_bits, byte}
    localparam logic [9:0] VEC [8] = '{
        {1'b0, 1'b0, 8'hA5}, {1'b1, 1'b0, 8'h3C}, {1'b0, 1'b1, 8'h81},
        {1'b1, 1'b1, 8'h7E}, {1'b0, 1'b0, 8'h01}, {1'b1, 1'b0, 8'h80},
        {1'b0, 1'b1, 8'hFF}, {1'b1, 1'b1, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // wrong-edge sampling returns the complement of b
    task automatic send_bit(input logic b, input logic en);
        ser_dat  = cfg_fall_edge ? ~b : b;
        bit_gate = en;
        wait_clk(4);
        ser_clk = 1'b1;
        wait_clk(2);
        ser_dat = cfg_fall_edge ? b : ~b;
        wait_clk(2);
        ser_clk = 1'b0;
        wait_clk(3);
    endtask

    task automatic send_byte(input logic [7:0] v, input logic junk);
        for (int i = 7; i >= 0; i--) begin
            send_bit(v[i], 1'b1);
            if (junk) send_bit(~v[i], 1'b0);
        end
        if (model.size() < 16) model.push_back(v);
        wait_clk(8);
    endtask

    task automatic pop_chk(input string tag);
        logic [7:0] e;
        e = model.pop_front();
        chk({tag, " valid"}, rd_valid, 1);
        chk({tag, " data"}, rd_data, e);
        rd_en = 1'b1;
        wait_clk(1);
        rd_en = 1'b0;
        wait_clk(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        chk("R9 reset rd_valid", rd_valid, 0);
        chk("R6 reset data_req", data_req, 1);

        // R1 R2 R3 R5: vector table
        for (int k = 0; k < 8; k++) begin
            cfg_fall_edge = VEC[k][9];
            send_byte(VEC[k][7:0], VEC[k][8]);
            pop_chk($sformatf("R1 R2 R3 vec%0d", k));
        end
        cfg_fall_edge = 1'b0;

        // R4: seven bits make no byte, eighth completes it
        for (int i = 6; i >= 0; i--) send_bit(1'b1, 1'b1);
        wait_clk(8);
        chk("R4 seven bits", rd_valid, 0);
        send_bit(1'b0, 1'b1);
        wait_clk(8);
        model.push_back(8'hFE);
        pop_chk("R4 eighth bit");

        // R3: only disabled bits
        for (int i = 0; i < 10; i++) send_bit(1'b1, 1'b0);
        wait_clk(8);
        chk("R3 gated only", rd_valid, 0);

        // R9: partial byte discarded on reset
        for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b1);
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        send_byte(8'h5A, 1'b0);
        pop_chk("R9 partial dropped");

        // R6 thresholds
        for (int i = 0; i < 11; i++) send_byte(8'(8'h10 + i), 1'b0);
        chk("R6 eleven bytes", data_req, 1);
        send_byte(8'h1B, 1'b0);
        chk("R6 twelve bytes", data_req, 0);
        // R7 hysteresis
        for (int i = 0; i < 4; i++) pop_chk("R7 drain");
        chk("R7 fill eight", data_req, 0);
        pop_chk("R7 drain");
        chk("R7 fill seven", data_req, 1);

        // R10: fill to 16 then one more dropped
        for (int i = 0; i < 9; i++) send_byte(8'(8'h40 + i), 1'b0);
        send_byte(8'hEE, 1'b0);
        for (int i = 0; i < 16; i++) pop_chk("R10 full drain");
        chk("R10 empty after drain", rd_valid, 0);

        // R8 inverted polarity
        cfg_req_inv = 1'b1;
        wait_clk(1);
        chk("R8 open inverted", data_req, 0);
        for (int i = 0; i < 12; i++) send_byte(8'(8'h60 + i), 1'b0);
        chk("R8 hold inverted", data_req, 1);
        for (int i = 0; i < 12; i++) pop_chk("R8 drain");
        chk("R8 reopen inverted", data_req, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule